// File: doc/BRIEF.md
# SD Data Timeout Watchdog

This block watches the data lines of an SD host controller while a transfer waits for the card. When software starts a transfer that expects data, the qualifier `wait_data` goes high. From then on a counter advances once for every SD clock enable tick. Each observed data activity pulse restarts the count. If the count reaches the programmed period, the block raises a sticky data-timeout status flag. This flag is kept separate from any CRC or end-bit error indication. Software clears the flag by writing one to it, which reaches the block as the `clr_flag` pulse.

The period is set by a 4-bit code `to_code` that comes from the controller's system control register, where the field occupies bits [19:16]. The period is 2^(code+BASE_SHIFT) SD clock ticks, with BASE_SHIFT = 13 in normal use. Codes above 14 are treated as 14, which gives a maximum of 2^27 ticks. The register that holds the code loads 14 at reset, so after reset the block waits for the longest period.

The block is built around three states. IDLE means no transfer is waiting. COUNT means a transfer is waiting and the counter runs. EXPIRED means the period has elapsed and the block holds until the wait ends. The transitions are:
- IDLE to COUNT when `wait_data` rises (the counter is cleared).
- COUNT to IDLE when `wait_data` falls.
- COUNT to EXPIRED on a tick where the count has reached the limit (the flag is set).
- EXPIRED to IDLE when `wait_data` falls.

Top module: `sd_dto_watchdog`

## Requirements
- R1: After reset `timeout_flag` and `busy` are both 0.
- R2: With `to_code` = c (c <= 14) held steady, `timeout_flag` rises on the edge that carries the 2^(c+BASE_SHIFT)-th tick seen after the edge on which the block entered COUNT. That entry edge is not counted, even if a tick is present on it.
- R3: Any `to_code` value from 15 to 15 (binary 1111) gives the same period as code 14.
- R4: The counter advances only on clock edges where `sd_tick` is 1. Edges without a tick leave it unchanged.
- R5: An `activity` pulse while counting clears the count, and the tick on that edge is not counted. Another 2^(c+BASE_SHIFT) ticks are then needed for expiry. Activity takes priority over an expiry on the same edge.
- R6: `timeout_flag` stays set until an edge with `clr_flag` = 1. Ending the wait or starting a new wait does not clear it. If an expiry and `clr_flag` fall on the same edge, the flag stays set.
- R7: `busy` is 1 only in COUNT. It is 0 after expiry and after `wait_data` falls. Dropping `wait_data` before expiry leaves the flag at 0.
- R8: If `to_code` is lowered while counting so that the count already meets the new limit, expiry occurs on the next tick. If `to_code` is raised, the longer period applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_tick | input | 1 | One-cycle SD clock enable tick |
| wait_data | input | 1 | High while a transfer waits on the data lines |
| activity | input | 1 | Pulse on observed data line activity |
| to_code | input | 4 | Timeout code from the system control register field |
| clr_flag | input | 1 | Write-one-to-clear pulse for the timeout flag |
| timeout_flag | output | 1 | Sticky data-timeout status |
| busy | output | 1 | High while the timeout counter is running |

## Verification
The hardest case to reach is a code change in the middle of a count. The lowered limit must fall below a count that has already built up, so that expiry fires on the very next tick instead of ever matching exactly. The bench builds up 40 ticks under a long code and then drops the code to a short period, with no activity in between. It then checks that the flag rises one tick later. A second hard case is the same-edge collision of expiry with `clr_flag` or with `activity`. The bench reaches it by counting ticks from the entry edge, so that the pulse lands exactly on the expiring tick.

// File: rtl/sd_dto_pkg.sv
package sd_dto_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } dto_state_e;

    localparam int unsigned CODE_W   = 4;
    localparam int unsigned CODE_MAX = 14;
endpackage

// File: rtl/sd_dto_limit.sv
module sd_dto_limit
    import sd_dto_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = 13,
    parameter int unsigned CNT_W      = BASE_SHIFT + CODE_MAX + 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  limit
);
    logic [CODE_W-1:0] eff_code;
    logic [CNT_W-1:0]  one_hot;

    always_comb begin
        eff_code = (code > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : code;
        one_hot  = CNT_W'(1) << (int'(eff_code) + int'(BASE_SHIFT));
        limit    = one_hot - CNT_W'(1);
    end
endmodule

// File: rtl/sd_dto_counter.sv
module sd_dto_counter #(
    parameter int unsigned CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (advance)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/sd_dto_watchdog.sv
module sd_dto_watchdog
    import sd_dto_pkg::*;
#(
    parameter int unsigned BASE_SHIFT = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_tick,
    input  logic              wait_data,
    input  logic              activity,
    input  logic [CODE_W-1:0] to_code,
    input  logic              clr_flag,
    output logic              timeout_flag,
    output logic              busy
);
    localparam int unsigned CNT_W = BASE_SHIFT + CODE_MAX + 1;

    dto_state_e       state_q, state_d;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;
    logic             hit;
    logic             cnt_clear;
    logic             cnt_adv;
    logic             set_flag;
    logic             flag_q;

    sd_dto_limit #(.BASE_SHIFT(BASE_SHIFT), .CNT_W(CNT_W)) u_limit (
        .code  (to_code),
        .limit (limit)
    );

    sd_dto_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .advance (cnt_adv),
        .count   (count)
    );

    assign hit = sd_tick && (count >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        cnt_clear = 1'b0;
        cnt_adv   = 1'b0;
        set_flag  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clear = 1'b1;
                if (wait_data)
                    state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!wait_data) begin
                    state_d   = ST_IDLE;
                    cnt_clear = 1'b1;
                end else if (activity) begin
                    cnt_clear = 1'b1;
                end else if (hit) begin
                    state_d   = ST_EXPIRED;
                    set_flag  = 1'b1;
                    cnt_clear = 1'b1;
                end else begin
                    cnt_adv = sd_tick;
                end
            end
            ST_EXPIRED: begin
                cnt_clear = 1'b1;
                if (!wait_data)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_flag)
            flag_q <= 1'b1;
        else if (clr_flag)
            flag_q <= 1'b0;
    end

    always_comb begin
        timeout_flag = flag_q;
        busy         = (state_q == ST_COUNT);
    end
endmodule

// File: rtl/sd_dto_checker.sv
module sd_dto_checker (
    input logic clk,
    input logic rst_n,
    input logic sd_tick,
    input logic wait_data,
    input logic activity,
    input logic clr_flag,
    input logic timeout_flag,
    input logic busy
);
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !clr_flag) |=> timeout_flag);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !busy) |=> !timeout_flag);

    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_data |=> !busy);

    a_r4_tick_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wait_data && !sd_tick && !timeout_flag) |=> !timeout_flag);

    a_r5_activity_first: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && activity && !timeout_flag) |=> !timeout_flag);

    a_r7_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> !busy);
endmodule

bind sd_dto_watchdog sd_dto_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sd_tick      (sd_tick),
    .wait_data    (wait_data),
    .activity     (activity),
    .clr_flag     (clr_flag),
    .timeout_flag (timeout_flag),
    .busy         (busy)
);

// File: tb/sim_sd_dto_watchdog.sv
module sim_sd_dto_watchdog;
    localparam int S = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sd_tick = 1'b0;
    logic       wait_data = 1'b0;
    logic       activity = 1'b0;
    logic [3:0] to_code = 4'd14;
    logic       clr_flag = 1'b0;
    logic       timeout_flag;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sd_dto_watchdog #(.BASE_SHIFT(S)) u0 (
        .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .wait_data(wait_data),
        .activity(activity), .to_code(to_code), .clr_flag(clr_flag),
        .timeout_flag(timeout_flag), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_clear();
        @(negedge clk);
        wait_data = 1'b0; sd_tick = 1'b0; activity = 1'b0; clr_flag = 1'b1;
        @(negedge clk);
        clr_flag = 1'b0;
        @(negedge clk);
    endtask

    // Raise wait, tick on every edge with index % period == 0 after the entry
    // edge, return ticks counted up to and including the expiring edge.
    task automatic measure(input int period, input int limit, output int ticks);
        ticks = 0;
        wait_data = 1'b1;
        sd_tick = 1'b1;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            if (i > 0 && sd_tick) ticks++;
            @(negedge clk);
            if (timeout_flag) break;
            sd_tick = ((i + 1) % period == 0);
        end
    endtask

    task automatic t_reset();
        check("R1 flag", timeout_flag, 0);
        check("R1 busy", busy, 0);
    endtask

    task automatic t_period();
        int t;
        idle_clear(); to_code = 4'd0; measure(1, 200, t);
        check("R2 code0 ticks", t, 1 << S);
        check("R7 busy after expiry", busy, 0);
        idle_clear(); to_code = 4'd3; measure(1, 200, t);
        check("R2 code3 ticks", t, 1 << (3 + S));
        idle_clear(); to_code = 4'd14; measure(1, 70000, t);
        check("R2 code14 ticks", t, 1 << (14 + S));
    endtask

    task automatic t_saturate();
        int t;
        idle_clear(); to_code = 4'd15; measure(1, 70000, t);
        check("R3 code15 ticks", t, 1 << (14 + S));
    endtask

    task automatic t_sparse();
        int t;
        int edges;
        idle_clear(); to_code = 4'd1;
        edges = 0;
        wait_data = 1'b1; sd_tick = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (timeout_flag) break;
            sd_tick = ((i % 3) == 2);
            @(posedge clk);
            edges++;
        end
        check("R4 edges with 1-in-3 ticks", edges, 3 * (1 << (1 + S)));
        t = 0;
    endtask

    task automatic t_activity();
        idle_clear(); to_code = 4'd1;
        wait_data = 1'b1; sd_tick = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) @(negedge clk);
        activity = 1'b1;
        @(negedge clk);
        activity = 1'b0;
        for (int i = 0; i < (1 << (1 + S)) - 1; i++) @(negedge clk);
        check("R5 no expiry one tick short", timeout_flag, 0);
        @(negedge clk);
        check("R5 expiry after restart", timeout_flag, 1);
        // activity on the expiring edge
        idle_clear(); to_code = 4'd0;
        wait_data = 1'b1; sd_tick = 1'b1;
        @(negedge clk);
        for (int i = 0; i < (1 << S) - 1; i++) @(negedge clk);
        activity = 1'b1;
        @(negedge clk);
        activity = 1'b0;
        check("R5 activity beats expiry", timeout_flag, 0);
        check("R5 still busy", busy, 1);
    endtask

    task automatic t_sticky();
        idle_clear(); to_code = 4'd0;
        wait_data = 1'b1; sd_tick = 1'b1;
        @(negedge clk);
        for (int i = 0; i < (1 << S) - 1; i++) @(negedge clk);
        clr_flag = 1'b1;
        @(negedge clk);
        clr_flag = 1'b0;
        check("R6 set beats clear", timeout_flag, 1);
        wait_data = 1'b0;
        @(negedge clk);
        wait_data = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R6 flag kept across new wait", timeout_flag, 1);
        check("R7 busy in new wait", busy, 1);
        clr_flag = 1'b1;
        @(negedge clk);
        clr_flag = 1'b0;
        check("R6 cleared by W1C", timeout_flag, 0);
    endtask

    task automatic t_abort();
        idle_clear(); to_code = 4'd0;
        wait_data = 1'b1; sd_tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wait_data = 1'b0;
        @(negedge clk);
        check("R7 busy low after wait ends", busy, 0);
        for (int i = 0; i < 10; i++) @(negedge clk);
        check("R7 no flag after abort", timeout_flag, 0);
    endtask

    task automatic t_code_change();
        idle_clear(); to_code = 4'd5;
        wait_data = 1'b1; sd_tick = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 40; i++) @(negedge clk);
        check("R8 not yet expired", timeout_flag, 0);
        to_code = 4'd1;
        @(negedge clk);
        check("R8 lowered code expires next tick", timeout_flag, 1);
        // raise code mid-count
        idle_clear(); to_code = 4'd0;
        wait_data = 1'b1; sd_tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        to_code = 4'd2;
        for (int i = 0; i < (1 << (2 + S)) - 2; i++) @(negedge clk);
        check("R8 raised code not yet expired", timeout_flag, 0);
        @(negedge clk);
        check("R8 raised code expires", timeout_flag, 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_saturate();
        t_sparse();
        t_activity();
        t_sticky();
        t_abort();
        t_code_change();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule